// File: doc/BRIEF.md
# Transmit Frame Sync Generator

This block produces the frame synchronisation waveform for the transmit half of a synchronous serial port. It also drives the serial data line while that sync is active. All state advances only on cycles where the bit-clock enable is high. A start-of-frame request opens a sync window. During the window the pin follows one of five waveforms, and the data line either carries bits taken from a sync holding word or rests at a configured default level. When the window closes, a one-cycle handoff strobe tells the payload shifter to begin. The payload shifter, clock division, FIFOs and register access sit outside this block.

The sync length is assembled from a low field and a separate high field, where the high field supplies the upper bits. A sync-edge flag pulses for one clock when the pin makes a transition in the selected direction. Every configuration input at zero gives an undriven pin, rising-edge flagging and the default data level on the line.

Top module: `txfs_gen`

## Requirements
- R1: After reset, with all configuration inputs at zero, `fs_out`, `fs_oe`, `tx_bit`, `sync_irq` and `pay_go` are all 0.
- R2: `cfg_mode` values 1 to 5 set `fs_oe` to 1. Values 0, 6 and 7 hold `fs_oe` and `fs_out` at 0, and the frame sequence still runs.
- R3: The sync length is N = {`cfg_len_hi`, `cfg_len_lo`}. A request accepted on a bit tick makes the sync active from the next tick for N+1 ticks. `pay_go` is then high for exactly one clock, starting at the tick after the last sync tick.
- R4: In mode 1 the pin is low while the sync is active and high otherwise. In mode 2 the pin is high while the sync is active and low otherwise.
- R5: In mode 4 the pin is high from the start of the sync until the bit tick on which `pay_done` is accepted, and low otherwise. Mode 3 gives the same waveform inverted.
- R6: In mode 5 the pin level inverts once for each accepted start-of-frame request and holds its value between frames.
- R7: With `cfg_sync_den`=1, sync tick j (counting from 0) drives bit N-j of `hold_word` when `cfg_msb_first`=1, and bit j when it is 0. Bit positions at or beyond the word width drive 0.
- R8: With `cfg_sync_den`=0, the sync ticks drive `cfg_dflt`. Outside the sync window `tx_bit` is always `cfg_dflt`.
- R9: `sync_irq` pulses for one clock on a rising pin transition (`cfg_edge_neg`=0) or a falling one (`cfg_edge_neg`=1), but only while `fs_oe` is 1.
- R10: Cycles with `bit_en` low change no output except `sync_irq` and `pay_go`. A request raised while the sync is active is ignored and does not alter its length.
- R11: A request accepted during the payload phase starts a new sync at once and takes priority over `pay_done` on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Bit-clock enable; all sequencing happens on these cycles |
| cfg_mode | input | 3 | Sync waveform select (0 none, 1 low pulse, 2 high pulse, 3 low during transfer, 4 high during transfer, 5 toggle) |
| cfg_len_lo | input | LEN_LO_W | Low part of the sync length |
| cfg_len_hi | input | LEN_HI_W | High part of the sync length |
| cfg_sync_den | input | 1 | 1: shift the holding word during the sync; 0: drive the default level |
| cfg_edge_neg | input | 1 | Sync-edge flag direction: 0 rising, 1 falling |
| cfg_msb_first | input | 1 | Holding word order: 1 from bit N downwards, 0 from bit 0 upwards |
| cfg_dflt | input | 1 | Default data line level |
| hold_word | input | HOLD_W | Sync holding word |
| sof_req | input | 1 | Start-of-frame request, sampled on bit ticks |
| pay_done | input | 1 | Payload finished, sampled on bit ticks |
| fs_out | output | 1 | Frame sync pin value |
| fs_oe | output | 1 | Frame sync pin output enable |
| tx_bit | output | 1 | Serial data line |
| sync_irq | output | 1 | One-clock sync-edge flag |
| pay_go | output | 1 | One-clock payload handoff strobe |

## Verification
The pin level, output enable and data bit that follow a bit tick are all due one clock later, because they come straight from the state registers that the tick updates. The sync-edge flag and the handoff strobe appear in that same clock and are gone one clock after. The bench samples each result at the falling edge after the enabled rising edge. It then samples again a full clock later, when `bit_en` is low, to confirm that the levels held and that the strobe was cleared. Sync-edge pulses are counted at falling edges and matched against the transitions that the bench's own expected pin sequence contains.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

   typedef enum logic [2:0] {
      FSM_NONE = 3'd0,
      FSM_NEG  = 3'd1,
      FSM_POS  = 3'd2,
      FSM_LOW  = 3'd3,
      FSM_HIGH = 3'd4,
      FSM_TOG  = 3'd5
   } fs_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_PAY  = 2'd2
   } phase_e;

   function automatic logic mode_drives(input logic [2:0] m);
      return (m >= 3'd1) && (m <= 3'd5);
   endfunction

endpackage

// File: rtl/txfs_seq.sv
module txfs_seq
   import txfs_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             sof_req,
   input  logic             pay_done,
   input  logic [LEN_W-1:0] sync_len,
   output phase_e           phase,
   output logic [LEN_W-1:0] cnt,
   output logic             acc,
   output logic             go
);

   if (LEN_W < 1) begin : g_chk_len
      $error("txfs_seq: LEN_W must be at least 1");
   end

   logic last;

   assign acc  = bit_en && sof_req && (phase != PH_SYNC);
   assign last = (cnt >= sync_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         go    <= 1'b0;
      end else begin
         go <= 1'b0;
         if (bit_en) begin
            case (phase)
               PH_IDLE: begin
                  if (sof_req) begin
                     phase <= PH_SYNC;
                     cnt   <= '0;
                  end
               end
               PH_SYNC: begin
                  if (last) begin
                     phase <= PH_PAY;
                     go    <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PH_PAY: begin
                  if (sof_req) begin
                     phase <= PH_SYNC;
                     cnt   <= '0;
                  end else if (pay_done) begin
                     phase <= PH_IDLE;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   // R3: the handoff strobe is one clock wide and follows the sync phase
   a_r3_go_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (phase == PH_PAY) && ($past(phase) == PH_SYNC));
   a_r3_go_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go);
   // R10: nothing advances without the bit enable
   a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(phase) && $stable(cnt));
   // R11: a request in the payload phase wins over payload done
   a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && sof_req && pay_done && phase == PH_PAY) |=> (phase == PH_SYNC) && (cnt == '0));

endmodule

// File: rtl/txfs_pin.sv
module txfs_pin
   import txfs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode,
   input  phase_e     phase,
   input  logic       acc,
   output logic       fs,
   output logic       oe
);

   fs_mode_e mode_e;
   logic     tog_q;
   logic     in_sync;
   logic     in_frame;

   assign mode_e   = fs_mode_e'(mode);
   assign in_sync  = (phase == PH_SYNC);
   assign in_frame = (phase != PH_IDLE);
   assign oe       = mode_drives(mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= 1'b0;
      end else if (acc && mode_e == FSM_TOG) begin
         tog_q <= ~tog_q;
      end
   end

   always_comb begin
      case (mode_e)
         FSM_NEG:  fs = ~in_sync;
         FSM_POS:  fs = in_sync;
         FSM_LOW:  fs = ~in_frame;
         FSM_HIGH: fs = in_frame;
         FSM_TOG:  fs = tog_q;
         default:  fs = 1'b0;
      endcase
   end

   // R2: an undriven pin reads as zero
   a_r2_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !fs);
   // R6: the toggle state holds when no request is accepted
   a_r6_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(tog_q));

endmodule

// File: rtl/txfs_dsel.sv
module txfs_dsel #(
   parameter int HOLD_W = 16,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_sync,
   input  logic              den,
   input  logic              msb_first,
   input  logic              dflt,
   input  logic [LEN_W-1:0]  sync_len,
   input  logic [LEN_W-1:0]  cnt,
   input  logic [HOLD_W-1:0] word,
   output logic              tx
);

   if (HOLD_W < 2) begin : g_chk_hold
      $error("txfs_dsel: HOLD_W must be at least 2");
   end

   logic [LEN_W-1:0]  idx;
   logic [HOLD_W-1:0] shifted;
   logic              word_bit;

   assign idx      = msb_first ? (sync_len - cnt) : cnt;
   assign shifted  = word >> idx;
   assign word_bit = shifted[0];
   assign tx       = (in_sync && den) ? word_bit : dflt;

   // R7: positions past the end of the holding word read as zero
   a_r7_past_end: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && den && (32'(idx) >= HOLD_W)) |-> !tx);
   // R8: outside the sync the line sits at the default level
   a_r8_idle_dflt: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sync |-> (tx == dflt));

endmodule

// File: rtl/txfs_irq.sv
module txfs_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fs,
   input  logic oe,
   input  logic edge_neg,
   output logic irq
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= fs;
   end

   assign irq = oe && (edge_neg ? (prev_q && !fs) : (!prev_q && fs));

   // R9: the flag appears only on a driven pin, and only at the selected level
   a_r9_only_oe: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> oe);
   a_r9_dir: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (fs == !edge_neg));

endmodule

// File: rtl/txfs_gen.sv
module txfs_gen
   import txfs_pkg::*;
#(
   parameter int LEN_LO_W = 4,
   parameter int LEN_HI_W = 4,
   parameter int HOLD_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_en,
   input  logic [2:0]          cfg_mode,
   input  logic [LEN_LO_W-1:0] cfg_len_lo,
   input  logic [LEN_HI_W-1:0] cfg_len_hi,
   input  logic                cfg_sync_den,
   input  logic                cfg_edge_neg,
   input  logic                cfg_msb_first,
   input  logic                cfg_dflt,
   input  logic [HOLD_W-1:0]   hold_word,
   input  logic                sof_req,
   input  logic                pay_done,
   output logic                fs_out,
   output logic                fs_oe,
   output logic                tx_bit,
   output logic                sync_irq,
   output logic                pay_go
);

   localparam int LEN_W = LEN_LO_W + LEN_HI_W;

   if (LEN_LO_W < 1 || LEN_HI_W < 1) begin : g_chk_fields
      $error("txfs_gen: both length fields need at least one bit");
   end

   logic [LEN_W-1:0] sync_len;
   logic [LEN_W-1:0] cnt;
   phase_e           phase;
   logic             acc;

   assign sync_len = {cfg_len_hi, cfg_len_lo};

   txfs_seq #(.LEN_W(LEN_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .sof_req  (sof_req),
      .pay_done (pay_done),
      .sync_len (sync_len),
      .phase    (phase),
      .cnt      (cnt),
      .acc      (acc),
      .go       (pay_go)
   );

   txfs_pin pin_i (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (cfg_mode),
      .phase (phase),
      .acc   (acc),
      .fs    (fs_out),
      .oe    (fs_oe)
   );

   txfs_dsel #(.HOLD_W(HOLD_W), .LEN_W(LEN_W)) dsel_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_sync   (phase == PH_SYNC),
      .den       (cfg_sync_den),
      .msb_first (cfg_msb_first),
      .dflt      (cfg_dflt),
      .sync_len  (sync_len),
      .cnt       (cnt),
      .word      (hold_word),
      .tx        (tx_bit)
   );

   txfs_irq irq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs       (fs_out),
      .oe       (fs_oe),
      .edge_neg (cfg_edge_neg),
      .irq      (sync_irq)
   );

   // R4: a pulse mode never drives the pin while the other pulse level is selected
   a_r4_pos_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 3'd2 && phase != PH_SYNC) |-> !fs_out);

endmodule

// File: tb/txfs_gen_tb_top.sv
module txfs_gen_tb_top;

   localparam int CLK_T  = 10;
   localparam int LO_W   = 4;
   localparam int HI_W   = 4;
   localparam int HW     = 16;
   localparam int PH_I   = 0;
   localparam int PH_S   = 1;
   localparam int PH_P   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bit_en = 1'b0;
   logic [2:0]      cfg_mode = '0;
   logic [LO_W-1:0] cfg_len_lo = '0;
   logic [HI_W-1:0] cfg_len_hi = '0;
   logic            cfg_sync_den = 1'b0;
   logic            cfg_edge_neg = 1'b0;
   logic            cfg_msb_first = 1'b0;
   logic            cfg_dflt = 1'b0;
   logic [HW-1:0]   hold_word = '0;
   logic            sof_req = 1'b0;
   logic            pay_done = 1'b0;
   logic            fs_out, fs_oe, tx_bit, sync_irq, pay_go;

   txfs_gen #(.LEN_LO_W(LO_W), .LEN_HI_W(HI_W), .HOLD_W(HW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_mode(cfg_mode),
      .cfg_len_lo(cfg_len_lo), .cfg_len_hi(cfg_len_hi), .cfg_sync_den(cfg_sync_den),
      .cfg_edge_neg(cfg_edge_neg), .cfg_msb_first(cfg_msb_first), .cfg_dflt(cfg_dflt),
      .hold_word(hold_word), .sof_req(sof_req), .pay_done(pay_done),
      .fs_out(fs_out), .fs_oe(fs_oe), .tx_bit(tx_bit), .sync_irq(sync_irq), .pay_go(pay_go)
   );

   always #(CLK_T/2) clk = ~clk;

   typedef struct {
      logic fs;
      logic oe;
      logic tx;
      logic go;
   } item_t;

   item_t q[$];
   int    total = 0;
   int    bad = 0;
   int    irq_seen = 0;
   int    irq_base = 0;
   int    irq_exp = 0;
   logic  tog_e = 1'b0;
   logic  prev_fs_e = 1'b0;
   int    ph_e = PH_I;
   bit    done_flag = 0;

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic exp_fs(input int ph);
      case (cfg_mode)
         3'd1: return ph != PH_S;
         3'd2: return ph == PH_S;
         3'd3: return ph == PH_I;
         3'd4: return ph != PH_I;
         3'd5: return tog_e;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic hbit(input int idx);
      if (idx >= 0 && idx < HW) return hold_word[idx];
      return 1'b0;
   endfunction

   function automatic int len_n();
      return int'({cfg_len_hi, cfg_len_lo});
   endfunction

   // count sync-edge pulses, one sample per clock
   always @(negedge clk) if (rst_n && sync_irq === 1'b1) irq_seen++;

   // monitor: compare outputs one clock after each enabled edge
   always @(posedge clk) begin
      if (bit_en === 1'b1) begin
         item_t it;
         @(negedge clk);
         if (q.size() == 0) begin
            check("R3 queue", 32'd0, 32'd1);
         end else begin
            it = q.pop_front();
            check("R4 fs_out", fs_out, it.fs);
            check("R2 fs_oe", fs_oe, it.oe);
            check("R7 tx_bit", tx_bit, it.tx);
            check("R3 pay_go", pay_go, it.go);
         end
      end
   end

   // driver: one bit tick, expected result queued before the edge
   task automatic tick(input logic sof, input logic done, input int ph, input int j, input logic go);
      item_t it;
      it.oe = (cfg_mode >= 3'd1 && cfg_mode <= 3'd5);
      it.fs = exp_fs(ph);
      it.tx = (ph == PH_S && cfg_sync_den) ? hbit(cfg_msb_first ? (len_n() - j) : j) : cfg_dflt;
      it.go = go;
      if (it.oe && it.fs != prev_fs_e && (cfg_edge_neg ? !it.fs : it.fs)) irq_exp++;
      prev_fs_e = it.fs;
      ph_e = ph;
      q.push_back(it);
      sof_req  = sof;
      pay_done = done;
      bit_en   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bit_en   = 1'b0;
      sof_req  = 1'b1;   // R10: request held during a disabled cycle must not count
      pay_done = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sof_req  = 1'b0;
      pay_done = 1'b0;
      check("R10 fs hold", fs_out, it.fs);
      check("R10 tx hold", tx_bit, it.tx);
      check("R3 go one clock", pay_go, 1'b0);
   endtask

   task automatic set_cfg(input logic [2:0] m, input int n, input logic den, input logic msbf,
                          input logic dflt, input logic eneg, input logic [HW-1:0] w);
      cfg_mode      = m;
      cfg_len_lo    = LO_W'(n);
      cfg_len_hi    = HI_W'(n >> LO_W);
      cfg_sync_den  = den;
      cfg_msb_first = msbf;
      cfg_dflt      = dflt;
      cfg_edge_neg  = eneg;
      hold_word     = w;
      repeat (3) @(posedge clk);
      @(negedge clk);
      irq_base  = irq_seen;
      irq_exp   = 0;
      prev_fs_e = exp_fs(ph_e);
   endtask

   task automatic frame(input int pay_n, input bit extra, input bit open_end);
      int n;
      n = len_n();
      if (cfg_mode == 3'd5) tog_e = ~tog_e;       // R6
      tick(1'b1, 1'b1, PH_S, 0, 1'b0);            // R11 when entered from payload
      for (int j = 1; j <= n; j++) tick(extra && j == 1, 1'b0, PH_S, j, 1'b0);  // R10 ignored request
      for (int p = 0; p < pay_n; p++) tick(1'b0, 1'b0, PH_P, 0, p == 0);
      if (!open_end) tick(1'b0, 1'b1, PH_I, 0, 1'b0);  // R5 ends at payload done
   endtask

   task automatic irq_check(input string tag);
      check(tag, irq_seen - irq_base, irq_exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 fs_out", fs_out, 1'b0);
      check("R1 fs_oe", fs_oe, 1'b0);
      check("R1 tx_bit", tx_bit, 1'b0);
      check("R1 sync_irq", sync_irq, 1'b0);
      check("R1 pay_go", pay_go, 1'b0);

      // R4 R7 positive pulse, msb first
      set_cfg(3'd2, 3, 1'b1, 1'b1, 1'b0, 1'b0, 16'hA5C3);
      frame(3, 0, 0);
      irq_check("R9 pos pulse");

      // R4 R7 negative pulse, lsb first, falling edge flag, default high
      set_cfg(3'd1, 5, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3C96);
      frame(2, 0, 0);
      irq_check("R9 neg pulse");

      // R5 R8 high during transfer, no sync data
      set_cfg(3'd4, 2, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF);
      frame(4, 0, 0);
      irq_check("R9 high level");

      // R5 R3 low during transfer, shortest sync
      set_cfg(3'd3, 0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001);
      frame(2, 0, 0);
      irq_check("R9 low level");

      // R6 R11 toggle across frames, one entered from the payload phase
      set_cfg(3'd5, 1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0002);
      frame(2, 0, 1);
      frame(1, 0, 0);
      frame(3, 0, 0);
      irq_check("R9 toggle");

      // R2 undriven pin, frames still shift data
      set_cfg(3'd0, 4, 1'b1, 1'b0, 1'b0, 1'b0, 16'h001B);
      frame(1, 0, 0);
      irq_check("R9 none mode");
      set_cfg(3'd6, 2, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000);
      frame(2, 0, 0);

      // R3 R7 length via high field past word width, request during sync ignored
      set_cfg(3'd2, 20, 1'b1, 1'b1, 1'b0, 1'b0, 16'hBEEF);
      frame(2, 1, 0);
      irq_check("R9 long sync");

      // R3 maximum length, lsb first
      set_cfg(3'd1, 255, 1'b1, 1'b0, 1'b1, 1'b0, 16'h8421);
      frame(1, 0, 0);
      irq_check("R9 max sync");

      repeat (2) @(negedge clk);
      check("R3 queue drained", q.size(), 0);
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule